// File: doc/BRIEF.md
# Shared-Pool Virtual-Channel Input Buffer

This block sits at one input port of a network-on-chip router. It keeps a single pool of flit slots. The slots are not partitioned among the virtual channels; a slot is bound to a channel only when a flit for that channel is written. Inside each channel, flits stay in arrival order through per-channel head and tail pointers and a next-slot table. A free-list of slot indices supplies a slot on every write and takes the slot back on every read. One busy channel can therefore fill the whole pool while its neighbours are idle. This suits wormhole traffic, where a long packet from one channel would overflow a fixed per-channel queue.

The write side is a valid/ready stream. A flit is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` falls only when no free slot is left. While `in_ready` is low the upstream must hold its flit; nothing is stored. The read side is a pull port for the downstream switch. The consumer raises `rd_req` together with a channel number on `rd_vc`. In the same cycle the block raises `out_valid` and shows that channel's oldest flit on `out_flit`. The flit is removed on the next clock edge. A request to an empty channel gives `out_valid` low and changes nothing. The per-channel occupancy, the per-channel empty flags and the global free-slot count are plain status outputs. Upstream credit logic uses the free-slot count.

Storage is arranged as one bank of `SLOTS_PER_VC` flits for each channel's worth of capacity. Write decode and read selection work once per bank and not once per slot.

Top module: `shared_vc_buffer`

## Requirements
- R1: After reset every channel is empty (all `vc_empty` bits 1, every occupancy 0), `free_slots` equals NUM_VC*SLOTS_PER_VC (16 by default) and `in_ready` is 1.
- R2: A write is taken on an edge with `in_valid` and `in_ready` both high. After that edge, the occupancy of channel `in_vc` is one higher and `free_slots` is one lower (if no read happens in the same cycle).
- R3: `in_ready` is 0 exactly when `free_slots` is 0. A flit offered while `in_ready` is 0 is not stored and changes no occupancy.
- R4: Flits of one channel are read in the order they were written.
- R5: Any single channel can hold every slot of the pool, 16 flits by default, while all other channels are empty.
- R6: When `rd_req` is 1 and channel `rd_vc` is not empty, `out_valid` is 1 in the same cycle and `out_flit` is that channel's oldest flit. The flit is removed on the next edge: occupancy falls by one and `free_slots` rises by one.
- R7: When `rd_req` is 1 and channel `rd_vc` is empty, `out_valid` is 0 and no occupancy or free count changes.
- R8: A write and a read in the same cycle are both carried out and `free_slots` stays the same. This includes a write to a channel whose only flit is being read in that cycle; afterwards the new flit is that channel's sole content.
- R9: Interleaved writes to several channels keep each channel's order, independent of the order in which the channels are drained.
- R10: `free_slots` plus the sum of all channel occupancies always equals the pool size. Slots freed by reads can be used again by any channel.
- R11: Each `vc_empty` bit is 1 exactly when that channel's occupancy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Write flit offered |
| in_ready | output | 1 | A free slot exists; write accepted when valid too |
| in_vc | input | $clog2(NUM_VC) | Channel of the offered flit |
| in_flit | input | FLIT_W | Offered flit |
| rd_req | input | 1 | Read request from the consumer |
| rd_vc | input | $clog2(NUM_VC) | Channel to read |
| out_valid | output | 1 | Requested channel held a flit; it leaves on this edge |
| out_flit | output | FLIT_W | Oldest flit of channel `rd_vc` |
| vc_empty | output | NUM_VC | One bit per channel, 1 when that channel holds nothing |
| vc_count | output | NUM_VC*$clog2(NUM_VC*SLOTS_PER_VC+1) | Occupancy of each channel, channel 0 in the low field |
| free_slots | output | $clog2(NUM_VC*SLOTS_PER_VC+1) | Number of unused slots in the pool |

## Verification
The pool is tested with a burst to one channel followed by a drain, which shows whether the arrival order survives the linked ordering. It is also tested with a fill of the whole pool through a single channel, which separates true sharing from a fixed split and exercises refusal when the pool is full. Alternating writes to two channels, drained in the reverse channel order, show whether the next-slot links of different channels stay apart when their slots interleave. Simultaneous read and write cycles are run on the same channel with a single flit and with several flits, and on different channels. These cases expose head/tail update races and free-list push/pop collisions. Reads of empty channels check that a miss leaves no trace.

// File: rtl/shvc_pkg.sv
package shvc_pkg;
  // Index width for n items, at least one bit.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/shvc_freelist.sv
module shvc_freelist #(
  parameter int unsigned TOTAL = 16,
  parameter int unsigned SW    = 4,
  parameter int unsigned CNTW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pop,
  output logic [SW-1:0]   pop_slot,
  input  logic            push,
  input  logic [SW-1:0]   push_slot,
  output logic [CNTW-1:0] free_cnt
);
  logic [SW-1:0]   ring [TOTAL];
  logic [SW-1:0]   rd_ptr, wr_ptr;
  logic [CNTW-1:0] cnt_q;

  assign pop_slot = ring[rd_ptr];
  assign free_cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) ring[i] <= SW'(i);
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= CNTW'(TOTAL);
    end else begin
      if (push) begin
        ring[wr_ptr] <= push_slot;
        wr_ptr <= (wr_ptr == SW'(TOTAL - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) begin
        rd_ptr <= (rd_ptr == SW'(TOTAL - 1)) ? '0 : rd_ptr + 1'b1;
      end
      cnt_q <= cnt_q + CNTW'(push) - CNTW'(pop);
    end
  end
endmodule

// File: rtl/shvc_bank.sv
module shvc_bank #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned LW     = 2,
  parameter int unsigned FLIT_W = 128
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LW-1:0]     waddr,
  input  logic [FLIT_W-1:0] wdata,
  input  logic [LW-1:0]     raddr,
  output logic [FLIT_W-1:0] rdata
);
  logic [FLIT_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/shvc_link.sv
module shvc_link #(
  parameter int unsigned NUM_VC = 4,
  parameter int unsigned TOTAL  = 16,
  parameter int unsigned SW     = 4,
  parameter int unsigned VW     = 2,
  parameter int unsigned CNTW   = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_fire,
  input  logic [VW-1:0]          wr_vc,
  input  logic [SW-1:0]          wr_slot,
  input  logic                   rd_fire,
  input  logic [VW-1:0]          rd_vc,
  output logic [SW-1:0]          rd_head,
  output logic [NUM_VC*CNTW-1:0] vc_cnt_flat,
  output logic [NUM_VC-1:0]      vc_empty
);
  logic [SW-1:0]   head_q [NUM_VC];
  logic [SW-1:0]   tail_q [NUM_VC];
  logic [CNTW-1:0] cnt_q  [NUM_VC];
  logic [SW-1:0]   next_q [TOTAL];
  logic [NUM_VC-1:0] wr_hit, rd_hit, handover;

  always_comb begin
    for (int v = 0; v < NUM_VC; v++) begin
      wr_hit[v]   = wr_fire && (wr_vc == VW'(v));
      rd_hit[v]   = rd_fire && (rd_vc == VW'(v));
      // write lands on a channel that is empty after this edge's read
      handover[v] = (cnt_q[v] == '0) || (rd_hit[v] && cnt_q[v] == CNTW'(1));
    end
  end

  assign rd_head = head_q[rd_vc];

  genvar g;
  generate
    for (g = 0; g < NUM_VC; g++) begin : g_stat
      assign vc_cnt_flat[g*CNTW +: CNTW] = cnt_q[g];
      assign vc_empty[g] = (cnt_q[g] == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_VC; v++) begin
        head_q[v] <= '0;
        tail_q[v] <= '0;
        cnt_q[v]  <= '0;
      end
    end else begin
      for (int v = 0; v < NUM_VC; v++) begin
        if (wr_hit[v]) tail_q[v] <= wr_slot;
        if (wr_hit[v] && handover[v])      head_q[v] <= wr_slot;
        else if (rd_hit[v])                head_q[v] <= next_q[head_q[v]];
        cnt_q[v] <= cnt_q[v] + CNTW'(wr_hit[v]) - CNTW'(rd_hit[v]);
      end
    end
  end

  // Link the new slot behind the current tail while the channel is in use.
  always_ff @(posedge clk) begin
    if (wr_fire && cnt_q[wr_vc] != '0) next_q[tail_q[wr_vc]] <= wr_slot;
  end
endmodule

// File: rtl/shared_vc_buffer.sv
module shared_vc_buffer #(
  parameter int unsigned NUM_VC       = 4,
  parameter int unsigned SLOTS_PER_VC = 4,
  parameter int unsigned FLIT_W       = 128,
  localparam int unsigned TOTAL = NUM_VC * SLOTS_PER_VC,
  localparam int unsigned SW    = shvc_pkg::idx_w(TOTAL),
  localparam int unsigned LW    = shvc_pkg::idx_w(SLOTS_PER_VC),
  localparam int unsigned VW    = shvc_pkg::idx_w(NUM_VC),
  localparam int unsigned CNTW  = $clog2(TOTAL + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [VW-1:0]          in_vc,
  input  logic [FLIT_W-1:0]      in_flit,
  input  logic                   rd_req,
  input  logic [VW-1:0]          rd_vc,
  output logic                   out_valid,
  output logic [FLIT_W-1:0]      out_flit,
  output logic [NUM_VC-1:0]      vc_empty,
  output logic [NUM_VC*CNTW-1:0] vc_count,
  output logic [CNTW-1:0]        free_slots
);
  localparam int unsigned BANKW = SW - LW;

  logic          wr_fire, rd_fire;
  logic [SW-1:0] alloc_slot, head_slot;
  logic [FLIT_W-1:0] bank_rdata [NUM_VC];

  assign in_ready  = (free_slots != '0);
  assign wr_fire   = in_valid && in_ready;
  assign rd_fire   = rd_req && !vc_empty[rd_vc];
  assign out_valid = rd_fire;

  shvc_freelist #(.TOTAL(TOTAL), .SW(SW), .CNTW(CNTW)) u_free (
    .clk(clk), .rst_n(rst_n),
    .pop(wr_fire), .pop_slot(alloc_slot),
    .push(rd_fire), .push_slot(head_slot),
    .free_cnt(free_slots)
  );

  shvc_link #(.NUM_VC(NUM_VC), .TOTAL(TOTAL), .SW(SW), .VW(VW), .CNTW(CNTW)) u_link (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_vc(in_vc), .wr_slot(alloc_slot),
    .rd_fire(rd_fire), .rd_vc(rd_vc), .rd_head(head_slot),
    .vc_cnt_flat(vc_count), .vc_empty(vc_empty)
  );

  genvar b;
  generate
    for (b = 0; b < NUM_VC; b++) begin : g_bank
      shvc_bank #(.DEPTH(SLOTS_PER_VC), .LW(LW), .FLIT_W(FLIT_W)) u_bank (
        .clk(clk),
        .we(wr_fire && alloc_slot[SW-1:LW] == BANKW'(b)),
        .waddr(alloc_slot[LW-1:0]),
        .wdata(in_flit),
        .raddr(head_slot[LW-1:0]),
        .rdata(bank_rdata[b])
      );
    end
  endgenerate

  assign out_flit = bank_rdata[head_slot[SW-1:LW]];
endmodule

// File: rtl/shared_vc_buffer_chk.sv
module shared_vc_buffer_chk #(
  parameter int unsigned NUM_VC = 4,
  parameter int unsigned CNTW   = 5,
  parameter int unsigned VW     = 2,
  parameter int unsigned TOTAL  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   rd_req,
  input logic [VW-1:0]          rd_vc,
  input logic                   out_valid,
  input logic [NUM_VC-1:0]      vc_empty,
  input logic [NUM_VC*CNTW-1:0] vc_count,
  input logic [CNTW-1:0]        free_slots
);
  logic [CNTW+VW:0] occ_sum;
  always_comb begin
    occ_sum = '0;
    for (int v = 0; v < NUM_VC; v++) occ_sum = occ_sum + (CNTW+VW+1)'(vc_count[v*CNTW +: CNTW]);
  end

  // R10
  conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_sum + (CNTW+VW+1)'(free_slots) == (CNTW+VW+1)'(TOTAL));

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && vc_empty[rd_vc]) |-> !out_valid);

  // R2
  write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !out_valid) |=> free_slots == $past(free_slots) - 1'b1);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !out_valid) |=> $stable(free_slots) && $stable(vc_count));

  // R8
  both_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_valid) |=> $stable(free_slots));

  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(in_valid && in_ready)) |=> free_slots == $past(free_slots) + 1'b1);

  genvar g;
  generate
    for (g = 0; g < NUM_VC; g++) begin : g_flag
      // R11
      empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vc_empty[g] == (vc_count[g*CNTW +: CNTW] == '0));
    end
  endgenerate
endmodule

bind shared_vc_buffer shared_vc_buffer_chk #(
  .NUM_VC(NUM_VC), .CNTW(CNTW), .VW(VW), .TOTAL(TOTAL)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .rd_req(rd_req), .rd_vc(rd_vc), .out_valid(out_valid),
  .vc_empty(vc_empty), .vc_count(vc_count), .free_slots(free_slots)
);

// File: tb/shared_vc_buffer_tb.sv
module shared_vc_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4, SPV = 4, FW = 128, TOT = NV * SPV, CW = 5, VW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, rd_req = 1'b0;
  logic [VW-1:0] in_vc = '0, rd_vc = '0;
  logic [FW-1:0] in_flit = '0;
  logic in_ready, out_valid;
  logic [FW-1:0] out_flit;
  logic [NV-1:0] vc_empty;
  logic [NV*CW-1:0] vc_count;
  logic [CW-1:0] free_slots;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_vc_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vc(in_vc), .in_flit(in_flit), .rd_req(rd_req), .rd_vc(rd_vc),
    .out_valid(out_valid), .out_flit(out_flit), .vc_empty(vc_empty),
    .vc_count(vc_count), .free_slots(free_slots)
  );

  function automatic logic [FW-1:0] mk(input int vc, input int seq);
    return {32'hC0DE0000 | 32'(vc), 32'(seq), ~32'(seq), 32'(vc * 1000 + seq)};
  endfunction

  function automatic int cnt(input int vc);
    return int'(vc_count[vc*CW +: CW]);
  endfunction

  task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Inputs change at negedge; results are looked at before the next change.
  task automatic wr(input int vc, input logic [FW-1:0] f);
    in_valid = 1'b1; in_vc = VW'(vc); in_flit = f;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rd(input string req, input int vc, input bit exp_v, input logic [FW-1:0] exp_f);
    rd_req = 1'b1; rd_vc = VW'(vc);
    #1;
    chk({req, " out_valid"}, FW'(out_valid), FW'(exp_v));
    if (exp_v) chk({req, " out_flit"}, out_flit, exp_f);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 free", FW'(free_slots), FW'(TOT));
    chk("R1 empty", FW'(vc_empty), FW'(4'hF));
    chk("R1 count", FW'(vc_count), '0);
    chk("R1 ready", FW'(in_ready), 1);
  endtask

  task automatic t_single_order;
    for (int i = 0; i < 5; i++) wr(1, mk(1, i));
    chk("R2 count", FW'(cnt(1)), 5);
    chk("R2 free", FW'(free_slots), FW'(TOT - 5));
    chk("R11 flag", FW'(vc_empty), FW'(4'hD));
    for (int i = 0; i < 5; i++) rd("R4 R6 order", 1, 1'b1, mk(1, i));
    chk("R6 drained", FW'(cnt(1)), 0);
    chk("R6 free", FW'(free_slots), FW'(TOT));
  endtask

  task automatic t_empty_read;
    wr(0, mk(0, 77));
    rd("R7 miss", 2, 1'b0, '0);
    chk("R7 count0", FW'(cnt(0)), 1);
    chk("R7 count2", FW'(cnt(2)), 0);
    chk("R7 free", FW'(free_slots), FW'(TOT - 1));
    rd("R7 then hit", 0, 1'b1, mk(0, 77));
  endtask

  task automatic t_fill_one;
    for (int i = 0; i < TOT; i++) wr(3, mk(3, i));
    chk("R5 full count", FW'(cnt(3)), FW'(TOT));
    chk("R3 not ready", FW'(in_ready), 0);
    chk("R3 free zero", FW'(free_slots), 0);
    wr(3, mk(3, 999));
    wr(1, mk(1, 999));
    chk("R3 ignored vc3", FW'(cnt(3)), FW'(TOT));
    chk("R3 ignored vc1", FW'(cnt(1)), 0);
    for (int i = 0; i < TOT; i++) rd("R5 R3 drain order", 3, 1'b1, mk(3, i));
    chk("R10 restored", FW'(free_slots), FW'(TOT));
    chk("R10 ready", FW'(in_ready), 1);
  endtask

  task automatic t_interleave;
    for (int i = 0; i < 6; i++) begin
      wr(0, mk(0, 100 + i));
      wr(2, mk(2, 200 + i));
    end
    chk("R9 count0", FW'(cnt(0)), 6);
    chk("R9 count2", FW'(cnt(2)), 6);
    for (int i = 0; i < 6; i++) rd("R9 vc2 order", 2, 1'b1, mk(2, 200 + i));
    for (int i = 0; i < 6; i++) rd("R9 vc0 order", 0, 1'b1, mk(0, 100 + i));
    chk("R10 free", FW'(free_slots), FW'(TOT));
  endtask

  task automatic t_simul;
    wr(0, mk(0, 1));
    // read the sole flit of vc0 while writing another to vc0
    in_valid = 1'b1; in_vc = 2'd0; in_flit = mk(0, 2);
    rd_req = 1'b1; rd_vc = 2'd0;
    #1;
    chk("R8 same-vc out", out_flit, mk(0, 1));
    @(negedge clk);
    in_valid = 1'b0; rd_req = 1'b0;
    chk("R8 same-vc count", FW'(cnt(0)), 1);
    chk("R8 same-vc free", FW'(free_slots), FW'(TOT - 1));
    // several flits in vc0, read and write same vc
    wr(0, mk(0, 3));
    in_valid = 1'b1; in_vc = 2'd0; in_flit = mk(0, 4);
    rd_req = 1'b1; rd_vc = 2'd0;
    #1;
    chk("R8 multi out", out_flit, mk(0, 2));
    @(negedge clk);
    in_valid = 1'b0; rd_req = 1'b0;
    chk("R8 multi free", FW'(free_slots), FW'(TOT - 2));
    // read vc0 while writing vc1
    in_valid = 1'b1; in_vc = 2'd1; in_flit = mk(1, 5);
    rd_req = 1'b1; rd_vc = 2'd0;
    #1;
    chk("R8 cross out", out_flit, mk(0, 3));
    @(negedge clk);
    in_valid = 1'b0; rd_req = 1'b0;
    chk("R8 cross free", FW'(free_slots), FW'(TOT - 2));
    rd("R8 R4 tail", 0, 1'b1, mk(0, 4));
    rd("R8 cross vc1", 1, 1'b1, mk(1, 5));
    chk("R10 end", FW'(free_slots), FW'(TOT));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_order();
    t_empty_read();
    t_fill_one();
    t_interleave();
    t_simul();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule